// File: doc/BRIEF.md
# Host-Loaded Lookup Curve Generator

This block maps an input sample onto an output sample through a curve held in a 512-entry table of 16-bit values. The host does not refresh the curve while samples are flowing. It delivers the whole curve once, word by word, over a valid/ready stream that a host-to-logic FIFO feeds. Every accepted word goes to the next table address, starting from address zero.

After reset the block sits in its load phase and does no lookups. It accepts exactly 512 words. Once the word for the last address is taken, it switches to run mode and closes the stream. In run mode, each valid input sample uses its upper nine bits as an unsigned table index. The entry read from the table appears at the output one cycle later. The only way to load a new curve is to reset the block, which returns it to an empty load phase.

Top module: `lut_profile_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `run_mode` is 0, `ld_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: In load mode a word is accepted on each clock edge where `ld_valid` and `ld_ready` are both 1. The first accepted word after reset is written to address 0 and each later word to the next address. A cycle with `ld_valid` low leaves the load address unchanged.
- R3: On the edge that accepts the word for address 511, the block leaves load mode. From the following cycle `run_mode` is 1 and `ld_ready` is 0.
- R4: In run mode `ld_ready` stays 0, and words offered on the load stream do not change any table entry.
- R5: Input samples offered in load mode are ignored. `out_valid` stays 0 and `out_data` stays 0.
- R6: In run mode a sample with `smp_valid` = 1 selects table entry `smp_in[15:7]` (unsigned). `out_valid` is 1 on the following cycle, and `out_data` then carries that entry. Entries 0 and 511 are reachable, and back-to-back samples produce back-to-back results.
- R7: In cycles where `out_valid` is 0, `out_data` holds the value of the most recent result.
- R8: A reset applied in run mode returns the block to load mode with the load address at 0. After that reset, lookups return only the newly loaded curve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restarts loading |
| ld_data | input | 16 | Curve word from the host stream |
| ld_valid | input | 1 | Curve word present |
| ld_ready | output | 1 | Block accepts curve words (load mode only) |
| smp_in | input | 16 | Input sample |
| smp_valid | input | 1 | Input sample present |
| out_data | output | 16 | Curve value for the last looked-up sample |
| out_valid | output | 1 | `out_data` updated this cycle |
| run_mode | output | 1 | 0 = loading, 1 = lookups enabled |

## Verification
The assertions run on every cycle and cover the control side of the block. They check that the load address moves by one per accepted word and holds otherwise, that run mode is entered only from the last address and is never left without a reset, that a result appears exactly one cycle after each run-mode sample and never from a load-mode sample, and that the output is stable between results. The bench scenarios are needed to show what the data path actually produces. They cover the correct address for each word across stalls, correct contents for every index including 0 and 511, words offered in run mode leaving the table intact, and a second curve replacing the first after a reset in run mode.

// File: rtl/lut_profile_pkg.sv
package lut_profile_pkg;
  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_RUN  = 1'b1
  } lut_mode_e;
endpackage

// File: rtl/lut_load_ctrl.sv
module lut_load_ctrl
  import lut_profile_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output lut_mode_e         mode
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  lut_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q;

  assign ld_ready = (mode_q == MODE_LOAD);
  assign wr_en    = ld_valid && ld_ready;
  assign wr_addr  = addr_q;
  assign mode     = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_LOAD;
      addr_q <= '0;
    end else if (wr_en) begin
      if (addr_q == LAST_ADDR) begin
        mode_q <= MODE_RUN;
        addr_q <= '0;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_q != LAST_ADDR) |=> (addr_q == $past(addr_q) + 1'b1)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_valid && mode_q == MODE_LOAD) |=> $stable(addr_q)); // R2
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LOAD && !(wr_en && addr_q == LAST_ADDR)) |=> (mode_q == MODE_LOAD)); // R3
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN) |=> (mode_q == MODE_RUN && !wr_en)); // R4
endmodule

// File: rtl/lut_table_ram.sv
module lut_table_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lut_index_map.sv
module lut_index_map #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                smp_valid,
  input  logic                run,
  output logic [ADDR_W-1:0]   rd_idx,
  output logic                rd_en,
  output logic                res_valid
);
  localparam int TOP = SAMPLE_W - 1;

  assign rd_idx = smp_in[TOP -: ADDR_W];
  assign rd_en  = smp_valid && run;

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= rd_en;
  end
endmodule

// File: rtl/lut_profile_gen.sv
module lut_profile_gen
  import lut_profile_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int DATA_W   = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   ld_data,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                smp_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_valid,
  output logic                run_mode
);
  localparam int ADDR_W = $clog2(DEPTH);

  lut_mode_e         mode;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_idx;
  logic              rd_en;

  lut_load_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .mode(mode)
  );

  lut_index_map #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_idx (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_valid(smp_valid),
    .run(mode == MODE_RUN), .rd_idx(rd_idx), .rd_en(rd_en), .res_valid(out_valid)
  );

  lut_table_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(ld_data),
    .re(rd_en), .raddr(rd_idx), .rdata(out_data)
  );

  assign run_mode = (mode == MODE_RUN);

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && run_mode) |=> out_valid); // R6
  AST_LOAD_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && run_mode) |=> !out_valid); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R7
  AST_READY_LOAD_ONLY: assert property (@(posedge clk) disable iff (rst)
    run_mode |-> !ld_ready); // R4
endmodule

// File: tb/tb_lut_profile_gen.sv
module tb_lut_profile_gen;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ld_data = '0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [15:0] smp_in = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] out_data;
  logic        out_valid;
  logic        run_mode;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] ref_tab [DEPTH];
  logic [15:0] exp_q [$];

  always #2ns clk = ~clk;

  lut_profile_gen dut (
    .clk(clk), .rst(rst), .ld_data(ld_data), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .smp_in(smp_in), .smp_valid(smp_valid), .out_data(out_data),
    .out_valid(out_valid), .run_mode(run_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_a(input int i);
    return 16'(i * i * 13 + i * 7 + 16'h0421);
  endfunction

  function automatic logic [15:0] pat_b(input int i);
    return 16'(16'hFFFF - i * 97);
  endfunction

  // Monitor: pops expected results from the scoreboard queue
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) chk("R5/R6 unexpected result", 1, 0);
      else chk("R6 lookup value", out_data, exp_q.pop_front());
    end
  end

  task automatic load_curve(input bit use_b);
    for (int i = 0; i < DEPTH; i++) begin
      ref_tab[i] = use_b ? pat_b(i) : pat_a(i);
      if (i % 7 == 3) begin
        @(negedge clk);
        ld_valid = 1'b0;
        ld_data  = 16'hBAD0;
      end
      @(negedge clk);
      if (i == DEPTH - 1) chk("R3 still loading before last word", run_mode, 0);
      ld_valid = 1'b1;
      ld_data  = ref_tab[i];
    end
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R3 run_mode after last word", run_mode, 1);
    chk("R3 ready low after last word", ld_ready, 0);
  endtask

  task automatic send(input int idx, input logic [6:0] low);
    @(negedge clk);
    smp_in    = {idx[8:0], low};
    smp_valid = 1'b1;
    exp_q.push_back(ref_tab[idx]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; ld_valid = 1'b0; smp_valid = 1'b0;
    @(negedge clk);
    chk("R1 run_mode in reset", run_mode, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 run_mode", run_mode, 0);
    chk("R1 ld_ready", ld_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_data", out_data, 0);
  endtask

  initial begin
    #(4ns * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset();

    // R5: samples during load are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      smp_in = 16'hFF80; smp_valid = 1'b1;
      chk("R5 out_valid during load", out_valid, 0);
      chk("R5 out_data during load", out_data, 0);
    end
    idle(1);

    load_curve(1'b0); // R2 with stalls

    // R4: words offered in run mode are not taken
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_data = 16'hDEAD;
      chk("R4 ld_ready in run", ld_ready, 0);
    end
    @(negedge clk);
    ld_valid = 1'b0;

    // R6: full sweep back-to-back, including entries 0 and 511; also proves R2/R4 contents
    for (int i = 0; i < DEPTH; i++) send(i, 7'(i * 5));
    idle(1);
    send(0, 7'h7F);
    send(511, 7'h00);
    idle(1);

    // R7: output holds between results
    send(100, 7'h11);
    idle(1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 out_data hold", out_data, ref_tab[100]);
      chk("R7 out_valid low", out_valid, 0);
    end

    // R8: reset in run mode, partial load, then new curve
    do_reset();
    @(negedge clk);
    ld_valid = 1'b1; ld_data = 16'h1111;
    @(negedge clk);
    ld_valid = 1'b0;
    chk("R8 still loading after partial load", run_mode, 0);
    do_reset();
    load_curve(1'b1);
    for (int i = 0; i < DEPTH; i += 37) send(i, 7'h40);
    send(511, 7'h7F);
    idle(3);

    chk("R6 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule